// File: doc/BRIEF.md
# Transmit Bit Clock and Sampler

This block makes the bit-rate clock that an external data source follows when it feeds a transmitter. It divides the reference clock by a programmable ratio. The source is expected to change its data line when the output clock falls. The block captures that line when the output clock rises, in the middle of the bit. Each captured bit goes to the modulator on a bit output, together with a one-cycle valid strobe. Because the block owns the timing, the data source never has to choose when to send.

The clock runs only while the mode input selects one of the two Gaussian-shaped keying modes that need a data clock. In every other mode the clock stays low. A new divider value or mode is applied only when a bit ends, so the clock never emits a shortened high phase.

Top module: `txbit_clock_sampler`

## Requirements
- R1: While `rst_n` is low at a rising reference edge, that edge drives `bclk_out`, `bit_valid` and `bit_out` to 0, and the divider state returns to idle.
- R2: One bit period lasts N reference cycles, where N is `cfg_div` and any value below 2 counts as 2. The period has ceil(N/2) low cycles followed by floor(N/2) high cycles.
- R3: A bit starts where `bclk_out` falls. The data source may change `data_in` at that point, and the value it presents is the one captured for that bit.
- R4: At the reference edge where `bclk_out` rises, `data_in` is captured into `bit_out`. `bit_out` holds that value until the next rise.
- R5: `bit_valid` is high for exactly one reference cycle, the first cycle in which `bclk_out` is high, and at no other time.
- R6: The clock runs only while `cfg_mode` is 3'd1 (Gaussian frequency-shift keying) or 3'd3 (Gaussian on-off keying). In any other mode `bclk_out` stays low and `bit_valid` never rises.
- R7: A change of `cfg_div` in the middle of a bit has no effect on that bit. The new ratio applies from the next bit boundary.
- R8: Leaving a clocked mode in the middle of a bit lets the current period finish, with its full high phase, before the clock stops low.
- R9: When a clocked mode is selected from idle, the next edge starts a new period with its low phase. The first rise follows ceil(N/2) low cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_div | input | DIV_W | Reference cycles per bit (values below 2 count as 2) |
| cfg_mode | input | 3 | Modulation mode; 1 and 3 enable the clock |
| data_in | input | 1 | Data line from the external source |
| bclk_out | output | 1 | Bit clock to the external source |
| bit_out | output | 1 | Last captured data bit |
| bit_valid | output | 1 | One-cycle strobe for a new captured bit |

## Verification
The hardest cases to reach are configuration changes that land inside a bit. A new ratio, or a mode that stops the clock, must wait for the boundary, and the high phase already under way must keep its full length. The stimulus watches `bclk_out` and makes these changes during a high phase, at a point it has picked. It then measures the low and high run lengths that follow, using a cycle model and counts taken at the ports. A second phase imitates a real data source: it changes `data_in` only on falls and queues each value it sends, so that every captured bit can be compared with the bit that was intended.

// File: rtl/txb_pkg.sv
// Shared definitions for the transmit bit clock block.
// Assumes a 3-bit modulation mode field driven by configuration logic.
package txb_pkg;
    localparam int MODE_W = 3;
    typedef logic [MODE_W-1:0] mode_t;

    // Mode codes that require a data clock
    localparam mode_t MODE_GFSK = 3'd1;
    localparam mode_t MODE_GOOK = 3'd3;

    // True when the given mode needs the bit clock running
    function automatic logic mode_clocked(input mode_t m);
        return (m == MODE_GFSK) || (m == MODE_GOOK);
    endfunction
endpackage

// File: rtl/txb_phase_ctr.sv
// Bit-period counter with configuration latched at bit boundaries.
// Produces the level the bit clock takes after the coming edge.
// Assumes cfg_div and cfg_mode are synchronous to clk.
module txb_phase_ctr
    import txb_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  mode_t            cfg_mode,
    output logic             high_next,
    output logic             active,
    output logic [DIV_W-1:0] n_cur
);
    localparam logic [DIV_W-1:0] N_MIN = DIV_W'(2);
    localparam logic [DIV_W-1:0] ONE   = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q, cnt_d, n_q, n_d, div_eff, low_d;
    logic             act_q, act_d, mode_ok, last_cyc;

    // Clamp the ratio and decode the mode
    always_comb begin
        div_eff  = (cfg_div < N_MIN) ? N_MIN : cfg_div;
        mode_ok  = mode_clocked(cfg_mode);
        last_cyc = (cnt_q == n_q - ONE);
    end

    // Next-state: start, wrap or stop only at a period boundary
    always_comb begin
        cnt_d = cnt_q;
        n_d   = n_q;
        act_d = act_q;
        if (!act_q) begin
            if (mode_ok) begin
                act_d = 1'b1;
                n_d   = div_eff;
                cnt_d = '0;
            end
        end else if (last_cyc) begin
            cnt_d = '0;
            if (mode_ok) begin
                n_d = div_eff;
            end else begin
                act_d = 1'b0;
            end
        end else begin
            cnt_d = cnt_q + ONE;
        end
        low_d     = n_d - (n_d >> 1);
        high_next = act_d && (cnt_d >= low_d);
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            n_q   <= N_MIN;
            act_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            n_q   <= n_d;
            act_q <= act_d;
        end
    end

    assign active = act_q;
    assign n_cur  = n_q;
endmodule

// File: rtl/txb_edge_gen.sv
// Registers the bit clock and flags the edge on which it rises.
// Assumes high_next comes from the phase counter in the same cycle.
module txb_edge_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic high_next,
    output logic bclk,
    output logic rise_now,
    output logic strobe
);
    // Rising edge is taking place at this clock edge
    assign rise_now = high_next && !bclk;

    // Clock level and one-cycle strobe registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk   <= 1'b0;
            strobe <= 1'b0;
        end else begin
            bclk   <= high_next;
            strobe <= rise_now;
        end
    end
endmodule

// File: rtl/txb_capture.sv
// Captures the data line on the bit clock's rising edge.
// Assumes data_in is stable around mid-bit.
module txb_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic data_in,
    output logic bit_q
);
    // Sample register, held between rising edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
        end else if (take) begin
            bit_q <= data_in;
        end
    end
endmodule

// File: rtl/txbit_clock_sampler.sv
// Top: bit clock for an external data source plus a mid-bit sampler.
// Assumes all inputs are synchronous to clk.
module txbit_clock_sampler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [2:0]       cfg_mode,
    input  logic             data_in,
    output logic             bclk_out,
    output logic             bit_out,
    output logic             bit_valid
);
    logic             high_next, rise_now, active;
    logic [DIV_W-1:0] n_cur;

    txb_phase_ctr #(.DIV_W(DIV_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_div   (cfg_div),
        .cfg_mode  (cfg_mode),
        .high_next (high_next),
        .active    (active),
        .n_cur     (n_cur)
    );

    txb_edge_gen u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .high_next (high_next),
        .bclk      (bclk_out),
        .rise_now  (rise_now),
        .strobe    (bit_valid)
    );

    txb_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (rise_now),
        .data_in (data_in),
        .bit_q   (bit_out)
    );
endmodule

// File: rtl/txb_checker.sv
// Property checker bound to the top; observes ports and divider state.
// Assumes a synchronous active-low reset.
module txb_checker #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bclk_out,
    input logic             bit_valid,
    input logic             bit_out,
    input logic             data_in,
    input logic             active,
    input logic [DIV_W-1:0] n_cur
);
    logic             prev_bclk;
    logic [DIV_W-1:0] hi_run, n_at_rise;

    // Track the length of each high run and the ratio it started with
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_bclk <= 1'b0;
            hi_run    <= '0;
            n_at_rise <= DIV_W'(2);
        end else begin
            prev_bclk <= bclk_out;
            hi_run    <= bclk_out ? hi_run + DIV_W'(1) : '0;
            if (bclk_out && !prev_bclk) n_at_rise <= n_cur;
        end
    end

    assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);

    assert_valid_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> (bclk_out && !prev_bclk));

    assert_sample_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> (bit_out == $past(data_in)));

    assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !bclk_out);

    assert_full_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_bclk && !bclk_out) |-> (hi_run == (n_at_rise >> 1)));

    assert_ratio_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        n_cur >= DIV_W'(2));

    assert_bit_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_valid && prev_bclk) |-> $stable(bit_out));
endmodule

bind txbit_clock_sampler txb_checker #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_out  (bclk_out),
    .bit_valid (bit_valid),
    .bit_out   (bit_out),
    .data_in   (data_in),
    .active    (active),
    .n_cur     (n_cur)
);

// File: tb/test_txbit_clock_sampler.sv
module test_txbit_clock_sampler;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] cfg_div = 8'd4;
    logic [2:0]       cfg_mode = 3'd0;
    logic             data_in = 1'b0;
    logic             bclk_out, bit_out, bit_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    // Behavioural model state
    int m_act = 0, m_cnt = 0, m_n = 2, m_bclk = 0, m_valid = 0, m_bit = 0;
    int rise_cnt = 0, valid_cnt = 0;
    bit src_mode = 1'b0;
    bit prev_seen = 1'b0;
    bit sent_q[$];
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    txbit_clock_sampler #(.DIV_W(DIV_W)) i_txbit_clock_sampler (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_mode(cfg_mode),
        .data_in(data_in), .bclk_out(bclk_out), .bit_out(bit_out),
        .bit_valid(bit_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model, advanced on every reference edge
    always @(posedge clk) begin
        int nd, nn, na, nc, nh;
        bit ok;
        if (!rst_n) begin
            m_act = 0; m_cnt = 0; m_n = 2; m_bclk = 0; m_valid = 0; m_bit = 0;
        end else begin
            ok = (cfg_mode == 3'd1) || (cfg_mode == 3'd3);
            nd = (cfg_div < 2) ? 2 : int'(cfg_div);
            na = m_act; nc = m_cnt; nn = m_n;
            if (m_act == 0) begin
                if (ok) begin na = 1; nn = nd; nc = 0; end
            end else if (m_cnt == m_n - 1) begin
                nc = 0;
                if (ok) nn = nd; else na = 0;
            end else begin
                nc = m_cnt + 1;
            end
            nh = (na != 0 && nc >= nn - nn / 2) ? 1 : 0;
            m_valid = (nh == 1 && m_bclk == 0) ? 1 : 0;
            if (m_valid == 1) m_bit = int'(data_in);
            m_bclk = nh; m_act = na; m_cnt = nc; m_n = nn;
        end
        cmp_en = 1'b1;
    end

    // Compare every cycle away from the active edge
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            check("R2 bclk_out", int'(bclk_out), m_bclk);
            check("R5 bit_valid", int'(bit_valid), m_valid);
            check("R4 bit_out", int'(bit_out), m_bit);
            if (bit_valid) begin
                valid_cnt++;
                if (src_mode && sent_q.size() > 0) begin
                    check("R3 captured bit equals sent bit", int'(bit_out), int'(sent_q.pop_front()));
                end
            end
            if (bclk_out && !prev_seen) rise_cnt++;
            if (src_mode) begin
                if (!bclk_out && prev_seen) begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    data_in = lfsr[0];
                    sent_q.push_back(lfsr[0]);
                end
            end else begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                data_in = lfsr[3];
            end
            prev_seen = bclk_out;
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Wait for a fall, then measure low and high run lengths
    task automatic measure(output int lo, output int hi);
        bit p;
        p = bclk_out;
        @(negedge clk);
        while (!(p && !bclk_out)) begin p = bclk_out; @(negedge clk); end
        lo = 0;
        while (!bclk_out) begin lo++; @(negedge clk); end
        hi = 0;
        while (bclk_out) begin hi++; @(negedge clk); end
    endtask

    task automatic wait_high();
        @(negedge clk);
        while (!bclk_out) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int lo, hi, r0, lows;
        // R1: reset state
        cycles(4);
        check("R1 reset bclk_out", int'(bclk_out), 0);
        check("R1 reset bit_valid", int'(bit_valid), 0);
        check("R1 reset bit_out", int'(bit_out), 0);
        rst_n = 1'b1;

        // R6: unclocked modes keep clock low
        cfg_div = 8'd6;
        foreach (cfg_mode[i]) begin end
        for (int m = 0; m < 8; m++) begin
            if (m == 1 || m == 3) continue;
            cfg_mode = 3'(m);
            r0 = rise_cnt;
            cycles(15);
            check("R6 no rise in unclocked mode", rise_cnt - r0, 0);
        end

        // R9: start from idle, first rise after ceil(N/2) lows
        cfg_div = 8'd5;
        cfg_mode = 3'd3;
        lows = 0;
        @(negedge clk);
        while (!bclk_out) begin lows++; @(negedge clk); end
        check("R9 lows before first rise", lows, 3);

        // R2: odd ratio split
        measure(lo, hi);
        check("R2 low cycles N=5", lo, 3);
        check("R2 high cycles N=5", hi, 2);

        // R3/R4: source-style data, changed only on falls
        cfg_mode = 3'd0;
        cycles(12);
        sent_q.delete();
        cfg_div = 8'd4;
        src_mode = 1'b1;
        data_in = 1'b1;
        sent_q.push_back(1'b1);
        cfg_mode = 3'd1;
        r0 = valid_cnt;
        cycles(80);
        check("R5 strobes in 80 cycles of N=4", valid_cnt - r0, 20);

        // R7: change ratio mid-high
        wait_high();
        cfg_div = 8'd7;
        measure(lo, hi);
        check("R7 new low after boundary", lo, 4);
        check("R7 new high after boundary", hi, 3);
        src_mode = 1'b0;

        // R2: ratios below 2 clamp to 2
        cfg_div = 8'd1;
        measure(lo, hi);
        measure(lo, hi);
        check("R2 clamp low", lo, 1);
        check("R2 clamp high", hi, 1);
        cfg_div = 8'd0;
        measure(lo, hi);
        measure(lo, hi);
        check("R2 zero clamp high", hi, 1);

        // R8: leave clocked mode during high phase
        cfg_div = 8'd6;
        measure(lo, hi);
        wait_high();
        cfg_mode = 3'd2;
        hi = 1;
        @(negedge clk);
        while (bclk_out) begin hi++; @(negedge clk); end
        check("R8 full high when stopping", hi, 3);
        r0 = rise_cnt;
        cycles(20);
        check("R8 idle after stop", rise_cnt - r0, 0);

        // R1: reset in mid-run
        cfg_mode = 3'd1;
        cfg_div = 8'd3;
        cycles(7);
        rst_n = 1'b0;
        cycles(2);
        check("R1 mid-run reset bclk_out", int'(bclk_out), 0);
        check("R1 mid-run reset bit_valid", int'(bit_valid), 0);
        rst_n = 1'b1;
        cycles(30);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule